// File: doc/BRIEF.md
# USB Endpoint Buffer Command Handler

This block sits between a processor command port and the per-endpoint packet buffer state of a USB device controller. The processor first picks an endpoint and then issues commands against it:

- read or write the packet buffer;
- free a received buffer;
- mark a transmit buffer ready;
- read the endpoint status;
- acknowledge a SETUP packet;
- set or clear a stall.

The serial engine side is reduced to two event inputs, a received-packet strobe and a packet-sent strobe, each carrying an endpoint index. The memory data path is reduced to one-cycle read and write strobes.

For each endpoint the block keeps a buffer-full flag, a stall flag and an interrupt bit. Endpoint 0 also keeps a SETUP-seen flag. When a SETUP packet lands on the control OUT endpoint, the block does three things:

- it discards any reply waiting in the control IN buffer;
- it blocks the free and ready commands on both control endpoints, so the SETUP data cannot be overwritten and no reply can leave before the processor has seen it;
- it holds this lock until the processor issues the acknowledge command.

Top module: `ep_cmd_top`

## Requirements
- R1: After reset, every buffer-full flag, interrupt bit, stall flag and SETUP-seen flag is 0, the SETUP lock is off, all pulse outputs are 0 and the selected endpoint (memEp) is 0.
- R2: Even endpoint indices are OUT endpoints and odd indices are IN endpoints. A non-SETUP packet received on an OUT endpoint whose buffer is empty sets that buffer's full flag and its interrupt bit. One arriving while the buffer is full is refused: rxNak pulses for one cycle, and the full flag and the interrupt bit are left as they were. A packet reported on an IN endpoint is ignored.
- R3: A packet-sent event on an IN endpoint whose buffer is full clears the full flag and sets the interrupt bit. On an empty buffer the event is ignored.
- R4: The status command (op 1) makes statValid pulse one cycle later, with statData = {stalled, setupSeen, full} of the selected endpoint. It also clears that endpoint's interrupt bit, except that an interrupt set in the same cycle wins.
- R5: The clear command (op 4) empties the selected buffer. The validate command (op 5) marks the buffer of a selected IN endpoint full, and has no effect on an OUT endpoint.
- R6: A SETUP packet on endpoint 0 is always accepted, even when the buffer is full. It sets endpoint 0's full, setupSeen and interrupt flags, empties endpoint 1's buffer and turns the SETUP lock on.
- R7: While the lock is on, clear or validate aimed at endpoint 0 or 1 is ignored and cmdReject pulses one cycle later. The same commands on other endpoints act normally and do not raise cmdReject.
- R8: The acknowledge command (op 6) turns the lock off and clears endpoint 0's setupSeen flag. After it, clear and validate act on the control endpoints again. A SETUP arriving in the same cycle wins.
- R9: The select command (op 0) makes cmdArg the selected endpoint, shown on memEp. The read-buffer (op 2) and write-buffer (op 3) commands give a one-cycle pulse on memRd or memWr, respectively, one cycle later.
- R10: The stall command (op 7) sets the selected endpoint's stalled flag to cmdArg[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| cmdArg | input | EP_W | Endpoint index for select, or stall value in bit 0 |
| rxValid | input | 1 | Serial engine received a packet |
| rxEp | input | EP_W | Endpoint of the received packet |
| rxSetup | input | 1 | Received packet is a SETUP |
| txDone | input | 1 | Serial engine sent a packet |
| txEp | input | EP_W | Endpoint of the sent packet |
| statValid | output | 1 | Status word valid |
| statData | output | 3 | {stalled, setupSeen, full} |
| cmdReject | output | 1 | Locked control command was dropped |
| memRd | output | 1 | Buffer read strobe |
| memWr | output | 1 | Buffer write strobe |
| memEp | output | EP_W | Selected endpoint |
| setupLock | output | 1 | SETUP lock active |
| epFull | output | NUM_EP | Buffer-full flags |
| epIrq | output | NUM_EP | Interrupt bits |
| rxNak | output | 1 | Received packet refused |

## Verification
The bench builds the block with NUM_EP = 4. This gives the two control endpoints plus one ordinary OUT endpoint (2) and one ordinary IN endpoint (3). With that set, a locked command on a control endpoint can be set against the same command on an ordinary endpoint in the same run. Refusal on a full OUT buffer, send completion on the ordinary IN endpoint, and SETUP overrun of a full control buffer are all exercised from the same table.

// File: rtl/ep_cmd_pkg.sv
package ep_cmd_pkg;

  typedef enum logic [2:0] {
    OP_SELECT   = 3'd0,
    OP_STATUS   = 3'd1,
    OP_RDBUF    = 3'd2,
    OP_WRBUF    = 3'd3,
    OP_CLEAR    = 3'd4,
    OP_VALIDATE = 3'd5,
    OP_ACKSETUP = 3'd6,
    OP_STALL    = 3'd7
  } cmdOp_e;

  // Strobes from control to datapath, all qualified for the selected endpoint
  typedef struct packed {
    logic clr;
    logic val;
    logic stat;
    logic ack;
    logic stallWr;
    logic stallVal;
  } cmdStrobe_t;

  typedef struct packed {
    logic stalled;
    logic setupSeen;
    logic full;
  } epStatus_t;

endpackage

// File: rtl/ep_cmd_ctrl.sv
module ep_cmd_ctrl
  import ep_cmd_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic [EP_W-1:0] cmdArg,
  input  logic            setupArrive,
  output cmdStrobe_t      strobe,
  output logic [EP_W-1:0] selEp,
  output logic            setupLock,
  output logic            cmdReject,
  output logic            memRd,
  output logic            memWr
);

  localparam logic [EP_W-1:0] CTRL_LAST = EP_W'(1);

  cmdOp_e opCode;
  logic   isCtrlSel;
  logic   isGuarded;
  logic   blocked;
  logic   lockNext;

  assign opCode    = cmdOp_e'(cmdOp);
  assign isCtrlSel = (selEp <= CTRL_LAST);
  assign isGuarded = (opCode == OP_CLEAR) || (opCode == OP_VALIDATE);
  assign blocked   = setupLock && isCtrlSel && isGuarded;

  always_comb begin
    strobe          = '0;
    strobe.stallVal = cmdArg[0];
    if (cmdValid) begin
      unique case (opCode)
        OP_CLEAR:    strobe.clr     = !blocked;
        OP_VALIDATE: strobe.val     = !blocked;
        OP_STATUS:   strobe.stat    = 1'b1;
        OP_ACKSETUP: strobe.ack     = 1'b1;
        OP_STALL:    strobe.stallWr = 1'b1;
        default:     ;
      endcase
    end
  end

  // A SETUP arriving in the same cycle as the acknowledge keeps the lock on
  always_comb begin
    lockNext = setupLock;
    if (strobe.ack) lockNext = 1'b0;
    if (setupArrive) lockNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selEp     <= '0;
      setupLock <= 1'b0;
      cmdReject <= 1'b0;
      memRd     <= 1'b0;
      memWr     <= 1'b0;
    end else begin
      setupLock <= lockNext;
      cmdReject <= cmdValid && blocked;
      memRd     <= cmdValid && (opCode == OP_RDBUF);
      memWr     <= cmdValid && (opCode == OP_WRBUF);
      if (cmdValid && (opCode == OP_SELECT)) selEp <= cmdArg;
    end
  end

endmodule

// File: rtl/ep_cmd_dp.sv
module ep_cmd_dp
  import ep_cmd_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [EP_W-1:0]   selEp,
  input  logic              setupArrive,
  input  logic              rxValid,
  input  logic [EP_W-1:0]   rxEp,
  input  logic              txDone,
  input  logic [EP_W-1:0]   txEp,
  output logic [NUM_EP-1:0] epFull,
  output logic [NUM_EP-1:0] epIrq,
  output logic              rxNak,
  output logic              statValid,
  output epStatus_t         statData
);

  logic [NUM_EP-1:0] stallV;
  logic [NUM_EP-1:0] setupV;
  logic [NUM_EP-1:0] nakVec;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam logic [EP_W-1:0] IDX     = EP_W'(i);
    localparam bit              IS_IN   = (i % 2) == 1;
    localparam bit              IS_FLUSH = (i == 1);

    logic selThis, rxHit, setupHit, accept, txHit, flush, clrHit, valHit;
    logic fullNext, irqNext;

    assign selThis  = (selEp == IDX);
    assign rxHit    = rxValid && (rxEp == IDX) && !IS_IN;
    assign setupHit = (i == 0) && setupArrive;
    assign accept   = rxHit && (setupHit || !epFull[i]);
    assign nakVec[i] = rxHit && !setupHit && epFull[i];
    assign txHit    = txDone && (txEp == IDX) && IS_IN && epFull[i];
    assign flush    = IS_FLUSH && setupArrive;
    assign clrHit   = strobe.clr && selThis;
    assign valHit   = strobe.val && selThis && IS_IN;

    // Priority: accepted packet, then emptying events, then validate
    always_comb begin
      fullNext = epFull[i];
      if (accept)                         fullNext = 1'b1;
      else if (flush || txHit || clrHit)  fullNext = 1'b0;
      else if (valHit)                    fullNext = 1'b1;
    end

    // Set wins over the status-read clear
    assign irqNext = (accept || txHit) || (epIrq[i] && !(strobe.stat && selThis));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        epFull[i] <= 1'b0;
        epIrq[i]  <= 1'b0;
        stallV[i] <= 1'b0;
      end else begin
        epFull[i] <= fullNext;
        epIrq[i]  <= irqNext;
        if (strobe.stallWr && selThis) stallV[i] <= strobe.stallVal;
      end
    end

    if (i == 0) begin : g_setup
      always_ff @(posedge clk) begin
        if (!rstN)          setupV[i] <= 1'b0;
        else if (setupHit)  setupV[i] <= 1'b1;
        else if (strobe.ack) setupV[i] <= 1'b0;
      end
    end else begin : g_nosetup
      assign setupV[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxNak     <= 1'b0;
      statValid <= 1'b0;
      statData  <= '0;
    end else begin
      rxNak     <= |nakVec;
      statValid <= strobe.stat;
      if (strobe.stat) begin
        statData.stalled   <= stallV[selEp];
        statData.setupSeen <= setupV[selEp];
        statData.full      <= epFull[selEp];
      end
    end
  end

endmodule

// File: rtl/ep_cmd_top.sv
module ep_cmd_top
  import ep_cmd_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [EP_W-1:0]   cmdArg,
  input  logic              rxValid,
  input  logic [EP_W-1:0]   rxEp,
  input  logic              rxSetup,
  input  logic              txDone,
  input  logic [EP_W-1:0]   txEp,
  output logic              statValid,
  output logic [2:0]        statData,
  output logic              cmdReject,
  output logic              memRd,
  output logic              memWr,
  output logic [EP_W-1:0]   memEp,
  output logic              setupLock,
  output logic [NUM_EP-1:0] epFull,
  output logic [NUM_EP-1:0] epIrq,
  output logic              rxNak
);

  cmdStrobe_t strobe;
  epStatus_t  statWord;
  logic       setupArrive;

  assign setupArrive = rxValid && rxSetup && (rxEp == '0);
  assign statData    = statWord;

  ep_cmd_ctrl #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .setupArrive(setupArrive), .strobe(strobe), .selEp(memEp), .setupLock(setupLock),
    .cmdReject(cmdReject), .memRd(memRd), .memWr(memWr)
  );

  ep_cmd_dp #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selEp(memEp), .setupArrive(setupArrive),
    .rxValid(rxValid), .rxEp(rxEp), .txDone(txDone), .txEp(txEp),
    .epFull(epFull), .epIrq(epIrq), .rxNak(rxNak), .statValid(statValid),
    .statData(statWord)
  );

endmodule

// File: rtl/ep_cmd_chk.sv
module ep_cmd_chk #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic              rxValid,
  input logic [EP_W-1:0]   rxEp,
  input logic              rxSetup,
  input logic              txDone,
  input logic [EP_W-1:0]   txEp,
  input logic              statValid,
  input logic              cmdReject,
  input logic              memRd,
  input logic              memWr,
  input logic [EP_W-1:0]   memEp,
  input logic              setupLock,
  input logic [NUM_EP-1:0] epFull,
  input logic [NUM_EP-1:0] epIrq,
  input logic              rxNak
);

  localparam logic [EP_W-1:0] CTRL_LAST = EP_W'(1);

  p_refuse_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxSetup && !rxEp[0] && epFull[rxEp] |=> rxNak);

  p_tx_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    txDone && txEp[0] && epFull[txEp] |=> epIrq[$past(txEp)] && !epFull[$past(txEp)]);

  p_stat_origin_r4: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> $past(cmdValid && (cmdOp == 3'd1)));

  p_setup_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxSetup && (rxEp == '0) |=> setupLock && epFull[0] && !epFull[1]);

  p_reject_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> $past(setupLock));

  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    setupLock && cmdValid && ((cmdOp == 3'd4) || (cmdOp == 3'd5)) && (memEp <= CTRL_LAST)
    && !rxValid && !txDone |=> cmdReject && $stable(epFull[1:0]));

  p_ack_unlock_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdOp == 3'd6) && !(rxValid && rxSetup && (rxEp == '0)) |=> !setupLock);

  p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !memWr);

endmodule

bind ep_cmd_top ep_cmd_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .rxValid(rxValid),
  .rxEp(rxEp), .rxSetup(rxSetup), .txDone(txDone), .txEp(txEp), .statValid(statValid),
  .cmdReject(cmdReject), .memRd(memRd), .memWr(memWr), .memEp(memEp),
  .setupLock(setupLock), .epFull(epFull), .epIrq(epIrq), .rxNak(rxNak)
);

// File: tb/ep_cmd_top_tb.sv
module ep_cmd_top_tb;

  localparam int NUM_EP = 4;
  localparam int EP_W   = 2;
  localparam int NROWS  = 23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [EP_W-1:0] cmdArg = '0;
  logic rxValid = 1'b0;
  logic [EP_W-1:0] rxEp = '0;
  logic rxSetup = 1'b0;
  logic txDone = 1'b0;
  logic [EP_W-1:0] txEp = '0;
  logic statValid, cmdReject, memRd, memWr, setupLock, rxNak;
  logic [2:0] statData;
  logic [EP_W-1:0] memEp;
  logic [NUM_EP-1:0] epFull, epIrq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ep_cmd_top #(.NUM_EP(NUM_EP)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .rxValid(rxValid), .rxEp(rxEp), .rxSetup(rxSetup), .txDone(txDone), .txEp(txEp),
    .statValid(statValid), .statData(statData), .cmdReject(cmdReject), .memRd(memRd),
    .memWr(memWr), .memEp(memEp), .setupLock(setupLock), .epFull(epFull), .epIrq(epIrq),
    .rxNak(rxNak)
  );

  // Row: req, cv, op, arg, rv, rep, rs, tv, tep, expFull, expIrq, expNak, expRej, expLock
  function automatic logic [31:0] row(input logic [3:0] req, input logic cv, input logic [2:0] op,
      input logic [1:0] arg, input logic rv, input logic [1:0] rep, input logic rs,
      input logic tv, input logic [1:0] tep, input logic [3:0] f, input logic [3:0] i,
      input logic n, input logic j, input logic l);
    return {req, cv, op, arg, rv, rep, rs, tv, tep, f, i, n, j, l, 4'd0};
  endfunction

  localparam logic [31:0] VEC [NROWS] = '{
    row(4'd2,  0,3'd0,2'd0, 1,2'd2,0, 0,2'd0, 4'b0100,4'b0100,0,0,0), // R2 accept on ep2
    row(4'd2,  0,3'd0,2'd0, 1,2'd2,0, 0,2'd0, 4'b0100,4'b0100,1,0,0), // R2 refused, full
    row(4'd9,  1,3'd0,2'd2, 0,2'd0,0, 0,2'd0, 4'b0100,4'b0100,0,0,0), // R9 select 2
    row(4'd4,  1,3'd1,2'd0, 0,2'd0,0, 0,2'd0, 4'b0100,4'b0000,0,0,0), // R4 status clears irq
    row(4'd5,  1,3'd4,2'd0, 0,2'd0,0, 0,2'd0, 4'b0000,4'b0000,0,0,0), // R5 clear
    row(4'd9,  1,3'd0,2'd3, 0,2'd0,0, 0,2'd0, 4'b0000,4'b0000,0,0,0), // R9 select 3
    row(4'd5,  1,3'd5,2'd0, 0,2'd0,0, 0,2'd0, 4'b1000,4'b0000,0,0,0), // R5 validate IN
    row(4'd3,  0,3'd0,2'd0, 0,2'd0,0, 1,2'd3, 4'b0000,4'b1000,0,0,0), // R3 sent
    row(4'd3,  0,3'd0,2'd0, 0,2'd0,0, 1,2'd3, 4'b0000,4'b1000,0,0,0), // R3 sent on empty ignored
    row(4'd9,  1,3'd0,2'd1, 0,2'd0,0, 0,2'd0, 4'b0000,4'b1000,0,0,0), // R9 select 1
    row(4'd5,  1,3'd5,2'd0, 0,2'd0,0, 0,2'd0, 4'b0010,4'b1000,0,0,0), // R5 validate ctrl IN
    row(4'd6,  0,3'd0,2'd0, 1,2'd0,1, 0,2'd0, 4'b0001,4'b1001,0,0,1), // R6 SETUP flushes ep1
    row(4'd7,  1,3'd4,2'd0, 0,2'd0,0, 0,2'd0, 4'b0001,4'b1001,0,1,1), // R7 clear ep1 locked
    row(4'd9,  1,3'd0,2'd0, 0,2'd0,0, 0,2'd0, 4'b0001,4'b1001,0,0,1), // R9 select 0
    row(4'd7,  1,3'd4,2'd0, 0,2'd0,0, 0,2'd0, 4'b0001,4'b1001,0,1,1), // R7 clear ep0 locked
    row(4'd2,  1,3'd0,2'd2, 1,2'd2,0, 0,2'd0, 4'b0101,4'b1101,0,0,1), // R2 select 2 + rx
    row(4'd7,  1,3'd4,2'd0, 0,2'd0,0, 0,2'd0, 4'b0001,4'b1101,0,0,1), // R7 ep2 unaffected
    row(4'd8,  1,3'd6,2'd0, 0,2'd0,0, 0,2'd0, 4'b0001,4'b1101,0,0,0), // R8 ack unlocks
    row(4'd9,  1,3'd0,2'd0, 0,2'd0,0, 0,2'd0, 4'b0001,4'b1101,0,0,0), // R9 select 0
    row(4'd8,  1,3'd4,2'd0, 0,2'd0,0, 0,2'd0, 4'b0000,4'b1101,0,0,0), // R8 clear works again
    row(4'd4,  1,3'd1,2'd0, 1,2'd0,0, 0,2'd0, 4'b0001,4'b1101,0,0,0), // R4 set wins over clear
    row(4'd2,  0,3'd0,2'd0, 1,2'd3,0, 0,2'd0, 4'b0001,4'b1101,0,0,0), // R2 rx on IN ignored
    row(4'd6,  0,3'd0,2'd0, 1,2'd0,1, 0,2'd0, 4'b0001,4'b1101,0,0,1)  // R6 SETUP over full
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic cv, input logic [2:0] op, input logic [1:0] arg,
      input logic rv, input logic [1:0] rep, input logic rs, input logic tv, input logic [1:0] tep);
    cmdValid = cv; cmdOp = op; cmdArg = arg;
    rxValid = rv; rxEp = rep; rxSetup = rs; txDone = tv; txEp = tep;
    @(negedge clk);
    cmdValid = 0; cmdOp = '0; cmdArg = '0;
    rxValid = 0; rxEp = '0; rxSetup = 0; txDone = 0; txEp = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs",
          {16'd0, epFull, epIrq, statValid, cmdReject, memRd, memWr, setupLock, rxNak, memEp},
          32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {28'd0, epFull}, 32'd0);

    for (int k = 0; k < NROWS; k++) begin
      logic [31:0] v;
      v = VEC[k];
      apply(v[27], v[26:24], v[23:22], v[21], v[20:19], v[18], v[17], v[16:15]);
      check($sformatf("R%0d row %0d", v[31:28], k),
            {19'd0, epFull, epIrq, rxNak, cmdReject, setupLock},
            {19'd0, v[14:4]});
    end

    // R6 / R4: status of ep0 after SETUP: {stall=0, setupSeen=1, full=1}
    apply(1, 3'd1, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R6 status ep0 setup seen", {28'd0, statValid, statData}, {28'd0, 1'b1, 3'b011});
    // R8: ack clears setupSeen
    apply(1, 3'd6, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    apply(1, 3'd1, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R8 setupSeen cleared", {28'd0, statValid, statData}, {28'd0, 1'b1, 3'b001});
    // R10: stall ep2
    apply(1, 3'd0, 2'd2, 0, 2'd0, 0, 0, 2'd0);
    apply(1, 3'd7, 2'd1, 0, 2'd0, 0, 0, 2'd0);
    apply(1, 3'd1, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R10 stalled bit", {28'd0, statValid, statData}, {28'd0, 1'b1, 3'b100});
    apply(0, 3'd0, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R4 statValid single pulse", {31'd0, statValid}, 32'd0);
    // R5: validate on OUT ep2 no effect
    apply(1, 3'd5, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R5 validate on OUT ignored", {28'd0, epFull}, 32'b0001);
    // R9: memory strobes
    apply(1, 3'd2, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R9 read strobe", {28'd0, memRd, memWr, memEp}, {28'd0, 1'b1, 1'b0, 2'd2});
    apply(1, 3'd3, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R9 write strobe", {28'd0, memRd, memWr, memEp}, {28'd0, 1'b0, 1'b1, 2'd2});
    apply(0, 3'd0, 2'd0, 0, 2'd0, 0, 0, 2'd0);
    check("R9 strobes drop", {30'd0, memRd, memWr}, 32'd0);

    finish_run();
  end

endmodule